// File: doc/BRIEF.md
# Write-Once Clock and Operating-Mode Control Register

This block is an 8-bit control register for the clock and operating mode of a small microcontroller. It sits on the CPU's register bus at one fixed address. It holds the clock divider selection, the oscillator enables, the oscillator type and the processor mode. It drives decoded control lines from those fields to the clock generator and the mode logic.

Three of the bits cannot be changed at will. These are the oscillator-type bit and the two processor-mode bits. Software gets a single plain write to them after reset, and after that write they freeze until the next reset. Freezing them stops runaway code from switching the oscillator type or the processor mode.

A bit-manipulation access is a read-modify-write. Such an access to the register never changes the frozen group, and it also sets the lock. The divider field is guarded as well: it cannot select double speed while RC oscillation is selected.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset the register reads 0x00, every decoded output is at its value for 0x00, and `lock_dbg` is 0.
- R2: Only accesses at address 0x3B touch the register. `bus_rdata` returns the current contents when `bus_addr` is 0x3B, whatever the lock state, and returns 0x00 at any other address. A write at any other address changes nothing.
- R3: A plain write (`bus_rmw` = 0) that arrives while the lock is clear loads all eight bits in that cycle, subject to R7. It then sets the lock.
- R4: Once the lock is set, a write leaves bits 5, 1 and 0 unchanged. Bits 7, 6, 4, 3 and 2 still take the written data, subject to R7.
- R5: A write with `bus_rmw` = 1 never changes bits 5, 1 and 0, even when the lock is clear. It updates the other bits, subject to R7, and it sets the lock.
- R6: The lock is set by the first write at 0x3B and is cleared only by reset. Its state is shown on `lock_dbg`.
- R7: Bits 7:6 form the divider field, and code 2'b10 means double speed. If a write would leave bit 5 at 1 (RC oscillation) together with code 2'b10, the divider field keeps its previous value. The rest of that write still takes effect. Double speed with RC oscillation is never visible.
- R8: The decoded outputs track the stored bits in the cycle after a write:
  - `osc_rc_sel` follows bit 5.
  - `main_osc_stop` follows bit 4.
  - `onchip_osc_stop` follows bit 3.
  - `proc_mode` follows bits 1:0.
  - `div_sel` follows bits 7:6.
  - `div_onehot` has only bit `div_sel` set.
  - `double_speed` is 1 exactly when `div_sel` is 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register bus address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rmw | input | 1 | Marks the write as part of a read-modify-write bit operation |
| bus_rdata | output | 8 | Register contents when addressed, else 0 |
| div_sel | output | 2 | Clock division ratio code (bits 7:6) |
| div_onehot | output | 4 | One-hot form of `div_sel` |
| double_speed | output | 1 | Divider code is double speed |
| osc_rc_sel | output | 1 | 1 selects RC oscillation, 0 selects ceramic or crystal |
| main_osc_stop | output | 1 | Main oscillator control (bit 4) |
| onchip_osc_stop | output | 1 | 1 stops the on-chip oscillator (bit 3) |
| proc_mode | output | 2 | Processor mode (bits 1:0) |
| lock_dbg | output | 1 | State of the write-once lock |

## Verification
A lock flag stuck at 0 shows up in the cycle after the second write: bits 5, 1 or 0 then change when they should hold, on `bus_rdata` and on `osc_rc_sel` or `proc_mode`. A lock that sets too early shows up in the cycle after the first plain write, because those bits do not load. A missing double-speed guard would let `double_speed` and `osc_rc_sel` be high together one cycle after the offending write. The bench compares every port against a behavioural model on every clock, so such faults are reported within one cycle of the write that exposes them.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

  localparam int unsigned CM_DATA_W = 8;

  // bit layout, MSB first: divider(7:6), rc(5), main stop(4), on-chip stop(3), spare(2), pmode(1:0)
  typedef struct packed {
    logic [1:0] div;
    logic       rc_sel;
    logic       main_stop;
    logic       onchip_stop;
    logic       spare;
    logic [1:0] pmode;
  } cm_reg_t;

  localparam logic [1:0]           CM_DIV_DOUBLE = 2'b10;
  localparam logic [CM_DATA_W-1:0] CM_ONCE_MASK  = 8'h23;
  localparam logic [CM_DATA_W-1:0] CM_RESET_VAL  = 8'h00;

  function automatic logic cm_div_legal(input logic [1:0] div, input logic rc);
    return !(rc && (div == CM_DIV_DOUBLE));
  endfunction

endpackage

// File: rtl/clkmode_rst_sync.sv
module clkmode_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/clkmode_bus_dec.sv
module clkmode_bus_dec #(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h3B
) (
  input  logic              bus_we,
  input  logic              bus_rmw,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              hit,
  output logic              wr_plain,
  output logic              wr_rmw
);

  always_comb begin
    hit      = (bus_addr == REG_ADDR);
    wr_plain = hit && bus_we && !bus_rmw;
    wr_rmw   = hit && bus_we &&  bus_rmw;
  end

endmodule

// File: rtl/clkmode_lock.sv
module clkmode_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_plain,
  input  logic wr_rmw,
  output logic locked,
  output logic freeze
);

  logic lock_q;
  logic lock_set;

  always_comb begin
    lock_set = (wr_plain || wr_rmw) && !lock_q;
    freeze   = lock_q || wr_rmw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lock_q <= 1'b0;
    else if (lock_set) lock_q <= 1'b1;
  end

  assign locked = lock_q;

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q); // R6

  AST_LOCK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_plain || wr_rmw) |=> lock_q); // R3

endmodule

// File: rtl/clkmode_store.sv
module clkmode_store
  import clkmode_pkg::*;
#(
  parameter logic [CM_DATA_W-1:0] RESET_VAL = CM_RESET_VAL,
  parameter logic [CM_DATA_W-1:0] ONCE_MASK = CM_ONCE_MASK
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 freeze,
  input  logic [CM_DATA_W-1:0] wdata,
  output logic [CM_DATA_W-1:0] q
);

  logic [CM_DATA_W-1:0] merged;
  cm_reg_t              cand;
  cm_reg_t              cur;
  logic [CM_DATA_W-1:0] q_d;

  // per-bit merge: the write-once group keeps its stored value while frozen
  for (genvar i = 0; i < CM_DATA_W; i++) begin : g_merge
    if (ONCE_MASK[i]) begin : g_once
      assign merged[i] = freeze ? q[i] : wdata[i];
    end else begin : g_free
      assign merged[i] = wdata[i];
    end
  end

  always_comb begin
    cur  = cm_reg_t'(q);
    cand = cm_reg_t'(merged);
    if (!cm_div_legal(cand.div, cand.rc_sel)) cand.div = cur.div;
    q_d = wr_en ? CM_DATA_W'(cand) : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RESET_VAL;
    else if (wr_en) q <= q_d;
  end

  AST_ONCE_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && freeze) |=> ((q & ONCE_MASK) == ($past(q) & ONCE_MASK))); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q)); // R2

  AST_NO_DOUBLE_RC: assert property (@(posedge clk) disable iff (!rst_n)
    !(q[5] && (q[7:6] == CM_DIV_DOUBLE))); // R7

endmodule

// File: rtl/clkmode_out_dec.sv
module clkmode_out_dec
  import clkmode_pkg::*;
#(
  parameter int unsigned DIV_W = 2,
  localparam int unsigned DIV_N = 1 << DIV_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CM_DATA_W-1:0] q,
  output logic [DIV_W-1:0]     div_sel,
  output logic [DIV_N-1:0]     div_onehot,
  output logic                 double_speed,
  output logic                 osc_rc_sel,
  output logic                 main_osc_stop,
  output logic                 onchip_osc_stop,
  output logic [1:0]           proc_mode
);

  cm_reg_t fields;

  always_comb begin
    fields          = cm_reg_t'(q);
    div_sel         = fields.div;
    osc_rc_sel      = fields.rc_sel;
    main_osc_stop   = fields.main_stop;
    onchip_osc_stop = fields.onchip_stop;
    proc_mode       = fields.pmode;
    double_speed    = (fields.div == CM_DIV_DOUBLE);
  end

  for (genvar k = 0; k < DIV_N; k++) begin : g_div_hot
    assign div_onehot[k] = (div_sel == DIV_W'(k));
  end

  AST_DIV_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(div_onehot) == 1); // R8

  AST_DSPEED_NOT_RC: assert property (@(posedge clk) disable iff (!rst_n)
    !(double_speed && osc_rc_sel)); // R7

endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
  import clkmode_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h3B
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [CM_DATA_W-1:0] bus_wdata,
  input  logic                 bus_we,
  input  logic                 bus_rmw,
  output logic [CM_DATA_W-1:0] bus_rdata,
  output logic [1:0]           div_sel,
  output logic [3:0]           div_onehot,
  output logic                 double_speed,
  output logic                 osc_rc_sel,
  output logic                 main_osc_stop,
  output logic                 onchip_osc_stop,
  output logic [1:0]           proc_mode,
  output logic                 lock_dbg
);

  logic                 rst_sync_n;
  logic                 hit;
  logic                 wr_plain;
  logic                 wr_rmw;
  logic                 freeze;
  logic [CM_DATA_W-1:0] q;

  clkmode_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  clkmode_bus_dec #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
    .bus_we   (bus_we),
    .bus_rmw  (bus_rmw),
    .bus_addr (bus_addr),
    .hit      (hit),
    .wr_plain (wr_plain),
    .wr_rmw   (wr_rmw)
  );

  clkmode_lock u_lock (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_plain (wr_plain),
    .wr_rmw   (wr_rmw),
    .locked   (lock_dbg),
    .freeze   (freeze)
  );

  clkmode_store u_store (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (wr_plain || wr_rmw),
    .freeze (freeze),
    .wdata  (bus_wdata),
    .q      (q)
  );

  clkmode_out_dec #(.DIV_W(2)) u_out (
    .clk             (clk),
    .rst_n           (rst_sync_n),
    .q               (q),
    .div_sel         (div_sel),
    .div_onehot      (div_onehot),
    .double_speed    (double_speed),
    .osc_rc_sel      (osc_rc_sel),
    .main_osc_stop   (main_osc_stop),
    .onchip_osc_stop (onchip_osc_stop),
    .proc_mode       (proc_mode)
  );

  always_comb begin
    bus_rdata = hit ? q : '0;
  end

  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !hit |-> (bus_rdata == '0)); // R2

endmodule

// File: tb/clkmode_ctrl_test.sv
`timescale 1ns/1ps
module clkmode_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_we;
  logic       bus_rmw;
  logic [7:0] bus_rdata;
  logic [1:0] div_sel;
  logic [3:0] div_onehot;
  logic       double_speed;
  logic       osc_rc_sel;
  logic       main_osc_stop;
  logic       onchip_osc_stop;
  logic [1:0] proc_mode;
  logic       lock_dbg;

  int n_tests = 0;
  int n_fail  = 0;
  int m_val   = 0;
  bit m_lock  = 0;

  always #4 clk = ~clk;

  clkmode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rmw(bus_rmw), .bus_rdata(bus_rdata),
    .div_sel(div_sel), .div_onehot(div_onehot), .double_speed(double_speed),
    .osc_rc_sel(osc_rc_sel), .main_osc_stop(main_osc_stop),
    .onchip_osc_stop(onchip_osc_stop), .proc_mode(proc_mode), .lock_dbg(lock_dbg)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int rd_exp;
    rd_exp = (bus_addr == 8'h3B) ? m_val : 0;
    check(tag, "rdata", int'(bus_rdata), rd_exp);
    check(tag, "lock", int'(lock_dbg), int'(m_lock));
    check(tag, "div_sel", int'(div_sel), (m_val >> 6) & 3);
    check(tag, "div_onehot", int'(div_onehot), 1 << ((m_val >> 6) & 3));
    check(tag, "double_speed", int'(double_speed), (((m_val >> 6) & 3) == 2) ? 1 : 0);
    check(tag, "osc_rc_sel", int'(osc_rc_sel), (m_val >> 5) & 1);
    check(tag, "main_osc_stop", int'(main_osc_stop), (m_val >> 4) & 1);
    check(tag, "onchip_osc_stop", int'(onchip_osc_stop), (m_val >> 3) & 1);
    check(tag, "proc_mode", int'(proc_mode), m_val & 3);
  endtask

  // behavioural model of one bus cycle, applied at the clock edge
  task automatic model_step(input bit we, input bit rmw, input int addr, input int data);
    int nv;
    if (we && addr == 'h3B) begin
      if (rmw || m_lock) nv = (m_val & 'h23) | (data & 'hDC);
      else               nv = data & 'hFF;
      if (((nv >> 6) & 3) == 2 && ((nv >> 5) & 1) == 1)
        nv = (nv & 'h3F) | (m_val & 'hC0);
      m_val  = nv;
      m_lock = 1;
    end
  endtask

  task automatic cycle(input bit we, input bit rmw, input int addr, input int data, input string tag);
    bus_we = we; bus_rmw = rmw; bus_addr = addr[7:0]; bus_wdata = data[7:0];
    @(posedge clk);
    model_step(we, rmw, addr, data);
    @(negedge clk);
    bus_we = 1'b0; bus_rmw = 1'b0;
    check_all(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    bus_we = 1'b0; bus_rmw = 1'b0; bus_addr = 8'h3B; bus_wdata = 8'h00;
    m_val = 0; m_lock = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R2: other addresses
    cycle(1, 0, 'h3A, 'hFF, "R2");
    cycle(1, 1, 'h3C, 'hFF, "R2");
    cycle(0, 0, 'h3B, 'h00, "R2");
    check("R2", "lock after miss", int'(lock_dbg), 0);

    // R3: first plain write loads all bits
    cycle(1, 0, 'h3B, 'h5E, "R3");
    check("R3", "value", int'(bus_rdata), 'h5E);
    // R4: frozen group holds
    cycle(1, 0, 'h3B, 'h21, "R4");
    check("R4", "value", int'(bus_rdata), 'h02);
    // R7/R8: double speed with ceramic accepted
    cycle(1, 0, 'h3B, 'h80, "R8");
    check("R8", "double_speed", int'(double_speed), 1);
    cycle(1, 0, 'h3B, 'hFF, "R4");
    check("R4", "value", int'(bus_rdata), 'hDE);
    // R6: lock stays through many writes and idle cycles
    for (int i = 0; i < 16; i++) cycle(1, i[0], 'h3B, i * 17, "R6");
    for (int i = 0; i < 4; i++) cycle(0, 0, 'h3B, 0, "R6");
    check("R6", "lock held", int'(lock_dbg), 1);
    cycle(0, 0, 'h10, 0, "R2");

    // new session: RC first, double speed rejected
    do_reset();
    check("R6", "lock cleared by reset", int'(lock_dbg), 0);
    cycle(1, 0, 'h3B, 'hA7, "R7");
    check("R7", "value", int'(bus_rdata), 'h27);
    cycle(1, 0, 'h3B, 'h80, "R7");
    check("R7", "value", int'(bus_rdata), 'h23);
    check("R7", "double_speed", int'(double_speed), 0);
    cycle(1, 0, 'h3B, 'h40, "R4");
    check("R4", "value", int'(bus_rdata), 'h63);

    // new session: read-modify-write first
    do_reset();
    cycle(1, 1, 'h3B, 'hFF, "R5");
    check("R5", "value", int'(bus_rdata), 'hDC);
    check("R5", "lock", int'(lock_dbg), 1);
    cycle(1, 0, 'h3B, 'h23, "R5");
    check("R5", "value", int'(bus_rdata), 'h00);

    // sweep of patterns from a fresh reset
    do_reset();
    for (int i = 0; i < 24; i++) cycle(1, (i % 3) == 0, 'h3B, (i * 53 + 7) & 'hFF, "R8");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule